// File: doc/BRIEF.md
# Control, Memory and Tape Execute Stage

This block sequences a single-cycle von Neumann machine with K registers of W bits and a byte-addressed memory. On every clock it fetches one instruction of 2W bits at the program counter, decodes it, and retires it in that same clock. It moves values between registers, conditionally or unconditionally, redirects the program counter on jumps that test a single flag, loads and stores bytes or words through a plain memory port, pulls words off an input tape, and stops for good when the answer instruction runs.

Arithmetic, logic and compare opcodes are not computed here. The stage sends the opcode, a function field and both operands to an attached ALU. It then writes back the result and the flag that the ALU returns. Instruction bytes and data bytes live in one external memory. The fetch port and the data port both read combinationally, and stores take effect at the clock edge.

Top module: `ctl_exec_stage`

## Requirements
- R1: Under synchronous active-high reset the program counter, flag, halted and accept outputs are all 0, and every register is cleared.
- R2: Any instruction other than a taken jump or the answer instruction advances the program counter by 2W/8 bytes, wrapping modulo 2^W (0xFFFC steps to 0x0000 when W=16).
- R3: The unconditional jump (opcode 0x12) loads the program counter with the last operand and leaves the flag and the registers unchanged.
- R4: Jump-if-set (0x13) is taken only when the flag is 1. Jump-if-clear (0x14) is taken only when the flag is 0. A jump that is not taken falls through by 2W/8.
- R5: Move (0x10) writes the last operand into register ri. Conditional move (0x11) writes it only when the flag is 1. Neither opcode changes the flag.
- R6: The instruction holds the opcode in its top 5 bits, then an immediate-select bit, then ri, then rj (each log2 K bits), then a function field. The low W bits form field A. When the select bit is 1 the last operand is A itself; when it is 0 the last operand is the register indexed by the low log2 K bits of A.
- R7: Word store (0x15) writes the full W bits of ri at the byte address given by the last operand. Byte store (0x16) asserts the byte-size strobe so that only the low byte of ri is written.
- R8: Word load (0x17) writes into ri the W/8 bytes at the operand address, taken little-endian. Byte load (0x18) writes the addressed byte into ri, zero-extended to W bits.
- R9: Tape read (0x19) with a word available writes that word into ri, clears the flag and consumes the word. When the tape is empty it writes 0, sets the flag and consumes nothing.
- R10: Answer (0x1F) raises halted and sets accept when its last operand is 0. From then until reset the program counter, flag and accept hold, and no store or tape pop is issued.
- R11: Opcodes 0x00 to 0x0F go to the ALU with rj as the first operand and the last operand as the second. The flag takes the ALU flag, and ri takes the ALU result only when the ALU asks for write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_addr | output | W | Program counter, the byte address of the instruction |
| fetch_instr | input | 2W | Instruction bytes at fetch_addr, little-endian |
| mem_addr | output | W | Data byte address |
| mem_wdata | output | W | Store data (value of ri) |
| mem_we | output | 1 | Store strobe |
| mem_byte | output | 1 | 1: byte access, 0: word access |
| mem_rdata | input | W | Little-endian word at mem_addr |
| tape_valid | input | 1 | Tape holds a word |
| tape_data | input | W | Next tape word |
| tape_pop | output | 1 | Consume the tape word |
| alu_op | output | 5 | Opcode sent to the ALU |
| alu_fn | output | W-1-5-2·log2K | Function field sent to the ALU |
| alu_a | output | W | First ALU operand (rj) |
| alu_b | output | W | Second ALU operand (last operand) |
| alu_res | input | W | ALU result |
| alu_flag | input | 1 | ALU flag result |
| alu_wb | input | 1 | ALU requests a write of ri |
| flag | output | 1 | Current flag |
| halted | output | 1 | Answer has executed |
| accept | output | 1 | Answered value was 0 |

## Verification
The bench follows the machine's own visible trace: the program counter and flag in every cycle, and every store. Because of this, a wrong register or flag value shows up within a few instructions. A corrupted register appears in the next store that reads it. A wrong flag shows up as soon as a conditional jump sends the program counter somewhere else, so it is seen on the following cycle. A missed wrap or a halt that fails to freeze shows in the program counter on the very next clock. A stray side effect after the answer instruction appears as a store that no expected item explains.

// File: rtl/ctl_pkg.sv
`timescale 1ns/1ps
package ctl_pkg;
  localparam int OPW = 5;

  localparam logic [OPW-1:0] OP_MOV  = 5'h10;
  localparam logic [OPW-1:0] OP_CMOV = 5'h11;
  localparam logic [OPW-1:0] OP_JMP  = 5'h12;
  localparam logic [OPW-1:0] OP_JSET = 5'h13;
  localparam logic [OPW-1:0] OP_JCLR = 5'h14;
  localparam logic [OPW-1:0] OP_STW  = 5'h15;
  localparam logic [OPW-1:0] OP_STB  = 5'h16;
  localparam logic [OPW-1:0] OP_LDW  = 5'h17;
  localparam logic [OPW-1:0] OP_LDB  = 5'h18;
  localparam logic [OPW-1:0] OP_TAPE = 5'h19;
  localparam logic [OPW-1:0] OP_ANS  = 5'h1F;

  typedef struct packed {
    logic alu;
    logic mov;
    logic cmov;
    logic jmp;
    logic jset;
    logic jclr;
    logic st;
    logic ld;
    logic bsz;
    logic tape;
    logic ans;
  } ctl_t;
endpackage

// File: rtl/ctl_decode.sv
`timescale 1ns/1ps
module ctl_decode
  import ctl_pkg::*;
#(
  parameter int W = 16,
  parameter int K = 8
) (
  input  logic [2*W-1:0]            instr,
  output ctl_t                      ctl,
  output logic [OPW-1:0]            op,
  output logic                      imm_sel,
  output logic [$clog2(K)-1:0]      ri_idx,
  output logic [$clog2(K)-1:0]      rj_idx,
  output logic [W-1-OPW-2*$clog2(K)-1:0] fn,
  output logic [W-1:0]              a_field
);
  localparam int RW  = $clog2(K);
  localparam int FNW = W - 1 - OPW - 2*RW;
  localparam int TOP = 2*W - 1;

  assign op      = instr[TOP -: OPW];
  assign imm_sel = instr[TOP-OPW];
  assign ri_idx  = instr[TOP-OPW-1 -: RW];
  assign rj_idx  = instr[TOP-OPW-1-RW -: RW];
  assign fn      = instr[W +: FNW];
  assign a_field = instr[W-1:0];

  always_comb begin
    ctl = '0;
    if (!op[OPW-1]) begin
      ctl.alu = 1'b1;
    end else begin
      case (op)
        OP_MOV:  ctl.mov  = 1'b1;
        OP_CMOV: ctl.cmov = 1'b1;
        OP_JMP:  ctl.jmp  = 1'b1;
        OP_JSET: ctl.jset = 1'b1;
        OP_JCLR: ctl.jclr = 1'b1;
        OP_STW:  ctl.st   = 1'b1;
        OP_STB:  begin ctl.st = 1'b1; ctl.bsz = 1'b1; end
        OP_LDW:  ctl.ld   = 1'b1;
        OP_LDB:  begin ctl.ld = 1'b1; ctl.bsz = 1'b1; end
        OP_TAPE: ctl.tape = 1'b1;
        OP_ANS:  ctl.ans  = 1'b1;
        default: ctl = '0;
      endcase
    end
  end

  always_comb begin
    a_one_role: assert (!(ctl.st && ctl.ld)) else $error("p_one_role_r6");
  end
endmodule

// File: rtl/ctl_regfile.sv
`timescale 1ns/1ps
module ctl_regfile #(
  parameter int W   = 16,
  parameter int K   = 8,
  parameter int NRD = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [$clog2(K)-1:0] waddr,
  input  logic [W-1:0]         wdata,
  input  logic [$clog2(K)-1:0] raddr [NRD],
  output logic [W-1:0]         rdata [NRD]
);
  logic [W-1:0] regs [K];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < K; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = regs[raddr[g]];
  end
endmodule

// File: rtl/ctl_seq.sv
`timescale 1ns/1ps
module ctl_seq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take,
  input  logic [W-1:0] target,
  input  logic         ans,
  input  logic         ans_zero,
  output logic [W-1:0] pc_q,
  output logic         halted_q,
  output logic         accept_q
);
  localparam logic [W-1:0] STEP = W'(2*W/8);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      halted_q <= 1'b0;
      accept_q <= 1'b0;
    end else if (!halted_q) begin
      if (ans) begin
        halted_q <= 1'b1;
        accept_q <= ans_zero;
      end else if (take) begin
        pc_q <= target;
      end else begin
        pc_q <= pc_q + STEP;
      end
    end
  end

  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    halted_q |=> halted_q && $stable(pc_q) && $stable(accept_q));
endmodule

// File: rtl/ctl_exec_stage.sv
`timescale 1ns/1ps
module ctl_exec_stage
  import ctl_pkg::*;
#(
  parameter int W = 16,
  parameter int K = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [W-1:0]         fetch_addr,
  input  logic [2*W-1:0]       fetch_instr,
  output logic [W-1:0]         mem_addr,
  output logic [W-1:0]         mem_wdata,
  output logic                 mem_we,
  output logic                 mem_byte,
  input  logic [W-1:0]         mem_rdata,
  input  logic                 tape_valid,
  input  logic [W-1:0]         tape_data,
  output logic                 tape_pop,
  output logic [OPW-1:0]       alu_op,
  output logic [W-1-OPW-2*$clog2(K)-1:0] alu_fn,
  output logic [W-1:0]         alu_a,
  output logic [W-1:0]         alu_b,
  input  logic [W-1:0]         alu_res,
  input  logic                 alu_flag,
  input  logic                 alu_wb,
  output logic                 flag,
  output logic                 halted,
  output logic                 accept
);
  localparam int RW  = $clog2(K);
  localparam int FNW = W - 1 - OPW - 2*RW;
  localparam logic [W-1:0] STEP = W'(2*W/8);

  ctl_t           ctl;
  logic [OPW-1:0] op;
  logic           imm_sel;
  logic [RW-1:0]  ri_idx, rj_idx;
  logic [FNW-1:0] fn;
  logic [W-1:0]   a_field;
  logic [RW-1:0]  raddr [3];
  logic [W-1:0]   rdata [3];
  logic [W-1:0]   a_val, wb_data;
  logic           wb_en, take, run, flag_q, flag_d;
  logic [W-1:0]   pc_q;
  logic           halted_q, accept_q;

  ctl_decode #(.W(W), .K(K)) u_dec (
    .instr(fetch_instr), .ctl(ctl), .op(op), .imm_sel(imm_sel),
    .ri_idx(ri_idx), .rj_idx(rj_idx), .fn(fn), .a_field(a_field)
  );

  assign raddr[0] = ri_idx;
  assign raddr[1] = rj_idx;
  assign raddr[2] = a_field[RW-1:0];

  ctl_regfile #(.W(W), .K(K), .NRD(3)) u_rf (
    .clk(clk), .rst(rst), .we(wb_en), .waddr(ri_idx), .wdata(wb_data),
    .raddr(raddr), .rdata(rdata)
  );

  assign run   = !halted_q;
  assign a_val = imm_sel ? a_field : rdata[2];
  assign take  = ctl.jmp | (ctl.jset & flag_q) | (ctl.jclr & ~flag_q);

  ctl_seq #(.W(W)) u_seq (
    .clk(clk), .rst(rst), .take(take), .target(a_val), .ans(ctl.ans),
    .ans_zero(a_val == '0), .pc_q(pc_q), .halted_q(halted_q), .accept_q(accept_q)
  );

  always_comb begin
    wb_data = a_val;
    wb_en   = 1'b0;
    flag_d  = flag_q;
    if (ctl.alu) begin
      wb_data = alu_res;
      wb_en   = alu_wb;
      flag_d  = alu_flag;
    end else if (ctl.mov) begin
      wb_en = 1'b1;
    end else if (ctl.cmov) begin
      wb_en = flag_q;
    end else if (ctl.ld) begin
      wb_data = ctl.bsz ? {{(W-8){1'b0}}, mem_rdata[7:0]} : mem_rdata;
      wb_en   = 1'b1;
    end else if (ctl.tape) begin
      wb_data = tape_valid ? tape_data : '0;
      wb_en   = 1'b1;
      flag_d  = ~tape_valid;
    end
    wb_en = wb_en & run;
  end

  always_ff @(posedge clk) begin
    if (rst)      flag_q <= 1'b0;
    else if (run) flag_q <= flag_d;
  end

  assign fetch_addr = pc_q;
  assign mem_addr   = a_val;
  assign mem_wdata  = rdata[0];
  assign mem_we     = run & ctl.st;
  assign mem_byte   = ctl.bsz;
  assign tape_pop   = run & ctl.tape & tape_valid;
  assign alu_op     = op;
  assign alu_fn     = fn;
  assign alu_a      = rdata[1];
  assign alu_b      = a_val;
  assign flag       = flag_q;
  assign halted     = halted_q;
  assign accept     = accept_q;

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (run && !take && !ctl.ans) |=> fetch_addr == $past(fetch_addr) + STEP);
  p_jump_r3: assert property (@(posedge clk) disable iff (rst)
    (run && ctl.jmp) |=> fetch_addr == $past(a_val) && flag_q == $past(flag_q));
  p_cmov_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (run && (ctl.cmov || ctl.mov)) |=> $stable(flag_q));
  p_tape_empty_r9: assert property (@(posedge clk) disable iff (rst)
    (run && ctl.tape && !tape_valid) |=> flag_q);
  p_tape_pop_r9: assert property (@(posedge clk) disable iff (rst)
    tape_pop |-> tape_valid);
  p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    halted_q |-> !mem_we && !tape_pop);
  p_frozen_flag_r10: assert property (@(posedge clk) disable iff (rst)
    halted_q |=> $stable(flag_q));
endmodule

// File: tb/ctl_exec_stage_tb.sv
`timescale 1ns/1ps
module ctl_exec_stage_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [15:0] fetch_addr, mem_addr, mem_wdata, mem_rdata, tape_data;
  logic [31:0] fetch_instr;
  logic        mem_we, mem_byte, tape_valid, tape_pop;
  logic [4:0]  alu_op;
  logic [3:0]  alu_fn;
  logic [15:0] alu_a, alu_b, alu_res;
  logic        alu_flag, alu_wb, flag, halted, accept;

  ctl_exec_stage #(.W(16), .K(8)) u_dut (
    .clk(clk), .rst(rst), .fetch_addr(fetch_addr), .fetch_instr(fetch_instr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_byte(mem_byte),
    .mem_rdata(mem_rdata), .tape_valid(tape_valid), .tape_data(tape_data),
    .tape_pop(tape_pop), .alu_op(alu_op), .alu_fn(alu_fn), .alu_a(alu_a), .alu_b(alu_b),
    .alu_res(alu_res), .alu_flag(alu_flag), .alu_wb(alu_wb), .flag(flag),
    .halted(halted), .accept(accept)
  );

  // byte memory (low 8 address bits), instructions and data share it
  logic [7:0] mem [256];
  always_comb begin
    fetch_instr = {mem[fetch_addr[7:0]+8'd3], mem[fetch_addr[7:0]+8'd2],
                   mem[fetch_addr[7:0]+8'd1], mem[fetch_addr[7:0]]};
    mem_rdata   = {mem[mem_addr[7:0]+8'd1], mem[mem_addr[7:0]]};
  end
  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata[7:0];
      if (!mem_byte) mem[mem_addr[7:0]+8'd1] <= mem_wdata[15:8];
    end
  end

  // tape model: two words
  int tape_idx;
  always @(posedge clk) begin
    if (rst) tape_idx <= 0;
    else if (tape_pop) tape_idx <= tape_idx + 1;
  end
  assign tape_valid = tape_idx < 2;
  assign tape_data  = (tape_idx == 0) ? 16'h1234 : 16'hBEEF;

  // ALU model: op 0 add (carry to flag), op 1 compare-equal (no write)
  always_comb begin
    alu_res = '0; alu_flag = 1'b0; alu_wb = 1'b0;
    if (alu_op == 5'h00) begin
      {alu_flag, alu_res} = {1'b0, alu_a} + {1'b0, alu_b};
      alu_wb = 1'b1;
    end else if (alu_op == 5'h01) begin
      alu_flag = (alu_a == alu_b);
    end
  end

  int checks = 0;
  int errors = 0;
  logic running = 1'b0;
  logic done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [4:0] op, input logic imm,
      input logic [2:0] ri, input logic [2:0] rj, input logic [15:0] a);
    return {op, imm, ri, rj, 4'b0000, a};
  endfunction

  task automatic put(input logic [7:0] addr, input logic [31:0] w);
    mem[addr]      <= w[7:0];
    mem[addr+8'd1] <= w[15:8];
    mem[addr+8'd2] <= w[23:16];
    mem[addr+8'd3] <= w[31:24];
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
  endtask

  // scoreboard queues
  logic [16:0] exp_tr[$];
  string       tag_tr[$];
  logic [32:0] exp_st[$];
  string       tag_st[$];

  task automatic push_tr(input logic [15:0] pc, input logic f, input string tag);
    exp_tr.push_back({f, pc});
    tag_tr.push_back(tag);
  endtask

  task automatic push_st(input logic b, input logic [15:0] a, input logic [15:0] d, input string tag);
    exp_st.push_back({b, a, d});
    tag_st.push_back(tag);
  endtask

  // monitor: pc/flag trace and store stream
  always @(negedge clk) begin
    if (running) begin
      if (exp_tr.size() > 0) begin
        logic [16:0] e;
        string t;
        e = exp_tr.pop_front();
        t = tag_tr.pop_front();
        chk({t, " pc"}, {16'h0, fetch_addr}, {16'h0, e[15:0]});
        chk({t, " flag"}, {31'h0, flag}, {31'h0, e[16]});
      end
      if (mem_we) begin
        if (exp_st.size() == 0) begin
          chk("R10 unexpected store", {mem_addr, mem_wdata}, 32'h0);
        end else begin
          logic [32:0] s;
          string t;
          s = exp_st.pop_front();
          t = tag_st.pop_front();
          chk({t, " store addr/size"}, {15'h0, mem_byte, mem_addr}, {15'h0, s[32], s[31:16]});
          if (s[32]) chk({t, " store byte"}, {24'h0, mem_wdata[7:0]}, {24'h0, s[7:0]});
          else       chk({t, " store word"}, {16'h0, mem_wdata}, {16'h0, s[15:0]});
        end
      end
    end
  end

  // opcodes
  localparam logic [4:0] ADD = 5'h00, CMPE = 5'h01, MOV = 5'h10, CMOV = 5'h11,
    JMP = 5'h12, JSET = 5'h13, JCLR = 5'h14, STW = 5'h15, STB = 5'h16,
    LDW = 5'h17, LDB = 5'h18, RDT = 5'h19, ANS = 5'h1F;

  task automatic driver_program1();
    clear_mem();
    put(8'h00, enc(JSET, 1, 0, 0, 16'h0078));
    put(8'h04, enc(MOV,  1, 1, 0, 16'h00C0));
    put(8'h08, enc(MOV,  1, 2, 0, 16'hC3F0));
    put(8'h0C, enc(STW,  0, 2, 0, 16'h0001));
    put(8'h10, enc(STB,  1, 2, 0, 16'h00C4));
    put(8'h14, enc(LDW,  1, 3, 0, 16'h00C0));
    put(8'h18, enc(LDB,  1, 4, 0, 16'h00C1));
    put(8'h1C, enc(LDW,  1, 5, 0, 16'h00C4));
    put(8'h20, enc(STW,  1, 3, 0, 16'h00C8));
    put(8'h24, enc(STW,  1, 4, 0, 16'h00CA));
    put(8'h28, enc(STW,  1, 5, 0, 16'h00CC));
    put(8'h2C, enc(ADD,  1, 6, 1, 16'hFF40));
    put(8'h30, enc(CMOV, 1, 7, 0, 16'h0055));
    put(8'h34, enc(JCLR, 1, 0, 0, 16'h0000));
    put(8'h38, enc(JSET, 1, 0, 0, 16'h0044));
    put(8'h3C, enc(STW,  1, 0, 0, 16'h00D0));
    put(8'h40, enc(STW,  1, 0, 0, 16'h00D0));
    put(8'h44, enc(STW,  1, 7, 0, 16'h00CE));
    put(8'h48, enc(STW,  1, 6, 0, 16'h00D2));
    put(8'h4C, enc(CMPE, 1, 0, 1, 16'h00C1));
    put(8'h50, enc(CMOV, 1, 7, 0, 16'h0AAA));
    put(8'h54, enc(JSET, 1, 0, 0, 16'h0000));
    put(8'h58, enc(JCLR, 1, 0, 0, 16'h0064));
    put(8'h5C, enc(STW,  1, 0, 0, 16'h00D0));
    put(8'h60, enc(STW,  1, 0, 0, 16'h00D0));
    put(8'h64, enc(STW,  1, 7, 0, 16'h00D4));
    put(8'h68, enc(RDT,  1, 1, 0, 16'h0000));
    put(8'h6C, enc(RDT,  1, 2, 0, 16'h0000));
    put(8'h70, enc(RDT,  1, 3, 0, 16'h0000));
    put(8'h74, enc(JMP,  1, 0, 0, 16'hFFFC));
    put(8'h78, enc(STW,  1, 2, 0, 16'h00D6));
    put(8'h7C, enc(STW,  1, 3, 0, 16'h00D8));
    put(8'h80, enc(ANS,  0, 0, 0, 16'h0003));
    put(8'h84, enc(STW,  1, 2, 0, 16'h00D0));
    put(8'hFC, enc(STW,  1, 1, 0, 16'h00DA));

    push_tr(16'h0000, 0, "R1");   push_tr(16'h0004, 0, "R4");
    push_tr(16'h0008, 0, "R5");   push_tr(16'h000C, 0, "R5");
    push_tr(16'h0010, 0, "R2");   push_tr(16'h0014, 0, "R2");
    push_tr(16'h0018, 0, "R2");   push_tr(16'h001C, 0, "R2");
    push_tr(16'h0020, 0, "R2");   push_tr(16'h0024, 0, "R2");
    push_tr(16'h0028, 0, "R2");   push_tr(16'h002C, 0, "R2");
    push_tr(16'h0030, 1, "R11");  push_tr(16'h0034, 1, "R5");
    push_tr(16'h0038, 1, "R4");   push_tr(16'h0044, 1, "R4");
    push_tr(16'h0048, 1, "R2");   push_tr(16'h004C, 1, "R2");
    push_tr(16'h0050, 0, "R11");  push_tr(16'h0054, 0, "R5");
    push_tr(16'h0058, 0, "R4");   push_tr(16'h0064, 0, "R4");
    push_tr(16'h0068, 0, "R2");   push_tr(16'h006C, 0, "R9");
    push_tr(16'h0070, 0, "R9");   push_tr(16'h0074, 1, "R9");
    push_tr(16'hFFFC, 1, "R3");   push_tr(16'h0000, 1, "R2");
    push_tr(16'h0078, 1, "R4");   push_tr(16'h007C, 1, "R2");
    push_tr(16'h0080, 1, "R2");   push_tr(16'h0080, 1, "R10");
    push_tr(16'h0080, 1, "R10");  push_tr(16'h0080, 1, "R10");

    push_st(0, 16'h00C0, 16'hC3F0, "R6");
    push_st(1, 16'h00C4, 16'h00F0, "R7");
    push_st(0, 16'h00C8, 16'hC3F0, "R8");
    push_st(0, 16'h00CA, 16'h00C3, "R8");
    push_st(0, 16'h00CC, 16'h00F0, "R7");
    push_st(0, 16'h00CE, 16'h0055, "R5");
    push_st(0, 16'h00D2, 16'h0000, "R11");
    push_st(0, 16'h00D4, 16'h0055, "R5");
    push_st(0, 16'h00DA, 16'h1234, "R9");
    push_st(0, 16'h00D6, 16'hBEEF, "R9");
    push_st(0, 16'h00D8, 16'h0000, "R9");
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    // phase 1: main program
    rst = 1'b1;
    driver_program1();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset pc", {16'h0, fetch_addr}, 32'h0);
    chk("R1 reset flags", {29'h0, flag, halted, accept}, 32'h0);
    @(posedge clk); #2;
    rst = 1'b0;
    running = 1'b1;
    repeat (40) @(negedge clk);
    running = 1'b0;
    chk("R7 all stores seen", exp_st.size(), 32'h0);
    chk("R10 halted", {31'h0, halted}, 32'h1);
    chk("R10 accept on zero", {31'h0, accept}, 32'h1);
    chk("R9 tape words consumed", tape_idx, 32'd2);

    // phase 2: answer with nonzero value
    rst = 1'b1;
    clear_mem();
    put(8'h00, enc(ANS, 1, 0, 0, 16'h0005));
    put(8'h04, enc(STW, 1, 0, 0, 16'h00D0));
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 reset after halt", {13'h0, halted, accept, flag, fetch_addr}, 32'h0);
    @(posedge clk); #2;
    rst = 1'b0;
    @(negedge clk);
    chk("R10 not yet halted", {31'h0, halted}, 32'h0);
    @(negedge clk);
    chk("R10 halted nonzero", {31'h0, halted}, 32'h1);
    chk("R10 no accept nonzero", {31'h0, accept}, 32'h0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R10 frozen pc", {16'h0, fetch_addr}, 32'h0);
      chk("R10 no store", {31'h0, mem_we}, 32'h0);
    end
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run();
    end
  end
endmodule